// File: doc/BRIEF.md
# Byte-Accessed Up/Down Counter with Atomic 16-bit Access

This block is a 16-bit counter that can be cleared, incremented or decremented on each enabled timer tick. A clock-select stage supplies the tick enables and a mode controller supplies the count, direction and clear controls. Software reaches the counter over an 8-bit data bus at two addresses, one for the low byte and one for the high byte.

A single temporary byte makes each 16-bit transfer atomic. Reading the low byte captures the counter's high byte into the temporary byte in the same cycle, so a later high-byte read returns a consistent pair. To write, software first writes the high byte, which lands only in the temporary byte. It then writes the low byte, which loads all 16 bits at once.

A bus write to the counter overrides any clear or count in that cycle. Two level flags report when the counter sits at zero and when it equals a programmable maximum. A one-cycle overflow request fires when an upward step wraps the counter from all-ones to zero.

Top module: `bictr16`

## Requirements
- R1: After reset the counter and the temporary byte are zero. `at_bottom` is 1 and `ovf_irq` is 0.
- R2: The high-byte address is `bus_addr`=1. Reading it returns the temporary byte. Writing it changes only the temporary byte and leaves the counter unchanged.
- R3: The low-byte address is `bus_addr`=0. Reading it returns the counter's bits 7:0 in the same cycle and copies bits 15:8 into the temporary byte at that clock edge.
- R4: Writing the low-byte address loads the counter with {temporary byte, bus data} at that clock edge.
- R5: A low-byte write takes priority over a clear or count step in the same cycle. The counter takes exactly the written value.
- R6: When `clk_sel` is 3'b000, ticks have no effect on the counter. Bus reads and writes still work.
- R7: On an enabled tick (`tick`=1, `clk_sel` non-zero) with `cnt_en`=1 and `clr`=0, the counter changes by one. It counts up when `dir_up`=1 and down when `dir_up`=0, wrapping modulo 2^16. With `cnt_en`=0 and `clr`=0 it holds.
- R8: On an enabled tick with `clr`=1, the counter becomes zero, whatever `cnt_en` and `dir_up` are.
- R9: `at_bottom` is 1 exactly when the counter is zero. `at_top` is 1 exactly when the counter equals `top_val`.
- R10: `ovf_irq` is 1 for one cycle, in the cycle after an enabled upward step moves the counter from 16'hFFFF to 16'h0000. A downward wrap or a bus write in that cycle raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable pulse from the prescaler |
| clk_sel | input | 3 | Clock-select field; zero stops the counter |
| cnt_en | input | 1 | Count step request from the mode controller |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| clr | input | 1 | Clear request, applied on an enabled tick |
| top_val | input | 16 | Maximum value compared for `at_top` |
| bus_addr | input | 1 | 0 selects low byte, 1 selects high (temporary) byte |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, valid while `bus_rd` is high; zero otherwise |
| at_top | output | 1 | Counter equals `top_val` |
| at_bottom | output | 1 | Counter equals zero |
| ovf_irq | output | 1 | One-cycle overflow request on an upward wrap |

## Verification
The assertions assume that the bus never raises `bus_rd` and `bus_wr` in the same cycle, so at most one byte access happens per clock. The stimulus drives each strobe from its own task, which raises one strobe for one cycle and lowers it before the next task runs. Every input changes on the falling clock edge, so the properties never see a control changing at the sampling edge. The priority scenarios combine a write with a tick, a clear and a count request, but they still use only one bus strobe.

// File: rtl/bictr16.sv
module bictr16 #(
  parameter int BW  = 8,
  parameter int CSW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CSW-1:0]    clk_sel,
  input  logic              cnt_en,
  input  logic              dir_up,
  input  logic              clr,
  input  logic [2*BW-1:0]   top_val,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BW-1:0]     bus_wdata,
  output logic [BW-1:0]     bus_rdata,
  output logic              at_top,
  output logic              at_bottom,
  output logic              ovf_irq
);
  localparam int CW = 2 * BW;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic [BW-1:0] tmp, tmp_nxt;
  logic          lo_rd, lo_wr, hi_rd, hi_wr, step, wrap_up;

  assign lo_rd = bus_rd && !bus_addr;
  assign hi_rd = bus_rd &&  bus_addr;
  assign lo_wr = bus_wr && !bus_addr;
  assign hi_wr = bus_wr &&  bus_addr;
  assign step  = tick && (clk_sel != '0);

  always_comb begin
    cnt_nxt = cnt;
    if (lo_wr)
      cnt_nxt = {tmp, bus_wdata};
    else if (step) begin
      if (clr)
        cnt_nxt = '0;
      else if (cnt_en)
        cnt_nxt = dir_up ? cnt + ONE : cnt - ONE;
    end
  end

  always_comb begin
    tmp_nxt = tmp;
    if (lo_rd)
      tmp_nxt = cnt[CW-1:BW];
    else if (hi_wr)
      tmp_nxt = bus_wdata;
  end

  assign wrap_up = step && !lo_wr && !clr && cnt_en && dir_up && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      tmp     <= '0;
      ovf_irq <= 1'b0;
    end else begin
      cnt     <= cnt_nxt;
      tmp     <= tmp_nxt;
      ovf_irq <= wrap_up;
    end
  end

  assign bus_rdata = lo_rd ? cnt[BW-1:0] : (hi_rd ? tmp : '0);
  assign at_bottom = (cnt == '0);
  assign at_top    = (cnt == top_val);

  // Input assumption: one bus strobe per cycle (R2, R3, R4)
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  a_r2_hi_wr_keeps_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !step) |=> $stable(cnt));

  a_r3_lo_rd_latch: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> tmp == $past(cnt[CW-1:BW]));

  a_r5_wr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> cnt == {$past(tmp), $past(bus_wdata)});

  a_r6_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_wr && clk_sel == '0) |=> $stable(cnt));

  a_r7_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !lo_wr && !clr && cnt_en && dir_up) |=> cnt == $past(cnt) + ONE);

  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !lo_wr && !clr && cnt_en && !dir_up) |=> cnt == $past(cnt) - ONE);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !lo_wr && clr) |=> cnt == '0);

  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |=> !ovf_irq);

  a_r10_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (cnt == '0));
endmodule

// File: tb/bictr16_tb.sv
module bictr16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [2:0]  clk_sel = 3'd0;
  logic        cnt_en = 1'b0;
  logic        dir_up = 1'b1;
  logic        clr = 1'b0;
  logic [15:0] top_val = 16'hFFFF;
  logic        bus_addr = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        at_top, at_bottom, ovf_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bictr16 dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clk_sel(clk_sel), .cnt_en(cnt_en),
    .dir_up(dir_up), .clr(clr), .top_val(top_val), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .at_top(at_top), .at_bottom(at_bottom), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [15:0] v);
    wr(1'b1, v[15:8]);
    wr(1'b0, v[7:0]);
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(1'b0, lo);
    rd(1'b1, hi);
    v = {hi, lo};
  endtask

  task automatic pulse;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] b;
    logic [15:0] v;
    chk("R1 bottom", {15'd0, at_bottom}, 16'd1);
    chk("R1 ovf", {15'd0, ovf_irq}, 16'd0);
    rd(1'b1, b);
    chk("R1 temp", {8'd0, b}, 16'h0000);
    rd16(v);
    chk("R1 count", v, 16'h0000);
  endtask

  task automatic t_high_byte;
    logic [7:0] b;
    wr(1'b1, 8'hA5);
    chk("R2 cnt untouched", {15'd0, at_bottom}, 16'd1);
    rd(1'b1, b);
    chk("R2 temp read", {8'd0, b}, 16'h00A5);
  endtask

  task automatic t_write_read;
    logic [15:0] v;
    logic [7:0] b;
    wr16(16'h1234);
    rd(1'b0, b);
    chk("R3 low read", {8'd0, b}, 16'h0034);
    rd(1'b1, b);
    chk("R4 loaded high", {8'd0, b}, 16'h0012);
    wr16(16'hBEEF);
    rd16(v);
    chk("R4 full load", v, 16'hBEEF);
  endtask

  task automatic t_latch;
    logic [7:0] b;
    logic [15:0] v;
    wr16(16'h12FF);
    clk_sel = 3'd1; cnt_en = 1'b1; dir_up = 1'b1;
    rd(1'b0, b);
    pulse();
    rd(1'b1, b);
    chk("R3 latched high", {8'd0, b}, 16'h0012);
    rd16(v);
    chk("R3 fresh pair", v, 16'h1300);
  endtask

  task automatic t_stopped;
    logic [15:0] v;
    wr16(16'h4000);
    clk_sel = 3'd0; cnt_en = 1'b1; dir_up = 1'b1;
    pulse(); pulse(); pulse();
    rd16(v);
    chk("R6 stopped hold", v, 16'h4000);
    wr16(16'h4321);
    rd16(v);
    chk("R6 write while stopped", v, 16'h4321);
  endtask

  task automatic t_count;
    logic [15:0] v;
    clk_sel = 3'd3; cnt_en = 1'b1; dir_up = 1'b1;
    wr16(16'h00FF);
    pulse();
    rd16(v);
    chk("R7 up carry", v, 16'h0100);
    dir_up = 1'b0;
    pulse();
    rd16(v);
    chk("R7 down borrow", v, 16'h00FF);
    cnt_en = 1'b0;
    pulse(); pulse();
    rd16(v);
    chk("R7 hold", v, 16'h00FF);
  endtask

  task automatic t_clear;
    logic [15:0] v;
    clk_sel = 3'd2; cnt_en = 1'b1; dir_up = 1'b1; clr = 1'b1;
    wr16(16'h7777);
    pulse();
    clr = 1'b0;
    rd16(v);
    chk("R8 clear over count", v, 16'h0000);
  endtask

  task automatic t_priority;
    logic [15:0] v;
    clk_sel = 3'd1; cnt_en = 1'b1; dir_up = 1'b1; clr = 1'b1;
    wr(1'b1, 8'h56);
    tick = 1'b1;
    wr(1'b0, 8'h78);
    tick = 1'b0;
    rd16(v);
    chk("R5 write over clear", v, 16'h5678);
    clr = 1'b0;
    wr(1'b1, 8'h9A);
    tick = 1'b1;
    wr(1'b0, 8'hBC);
    tick = 1'b0;
    rd16(v);
    chk("R5 write over count", v, 16'h9ABC);
    clr = 1'b0;
  endtask

  task automatic t_flags;
    top_val = 16'h0003;
    clk_sel = 3'd1; cnt_en = 1'b1; dir_up = 1'b1;
    wr16(16'h0001);
    chk("R9 top low", {15'd0, at_top}, 16'd0);
    pulse();
    chk("R9 top below", {15'd0, at_top}, 16'd0);
    pulse();
    chk("R9 top hit", {15'd0, at_top}, 16'd1);
    chk("R9 bottom off", {15'd0, at_bottom}, 16'd0);
    pulse();
    chk("R9 top past", {15'd0, at_top}, 16'd0);
    wr16(16'h0000);
    chk("R9 bottom on", {15'd0, at_bottom}, 16'd1);
    top_val = 16'hFFFF;
  endtask

  task automatic t_overflow;
    logic [15:0] v;
    clk_sel = 3'd1; cnt_en = 1'b1; dir_up = 1'b1;
    wr16(16'hFFFF);
    chk("R9 top at max", {15'd0, at_top}, 16'd1);
    pulse();
    chk("R10 ovf pulse", {15'd0, ovf_irq}, 16'd1);
    chk("R10 wrapped", {15'd0, at_bottom}, 16'd1);
    @(negedge clk);
    chk("R10 ovf one cycle", {15'd0, ovf_irq}, 16'd0);
    dir_up = 1'b0;
    pulse();
    chk("R10 no ovf down", {15'd0, ovf_irq}, 16'd0);
    rd16(v);
    chk("R7 down wrap", v, 16'hFFFF);
    dir_up = 1'b1;
    wr(1'b1, 8'hFF);
    tick = 1'b1;
    wr(1'b0, 8'hFF);
    tick = 1'b0;
    chk("R10 no ovf on write", {15'd0, ovf_irq}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_high_byte();
    t_write_read();
    t_latch();
    t_stopped();
    t_count();
    t_clear();
    t_priority();
    t_flags();
    t_overflow();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule